// File: doc/BRIEF.md
# I2C Register-File Target

This block lets an external I2C controller read and write a small bank of byte-wide registers. It watches the two bus lines through synchronizers running on the system clock. From them it recognizes START, repeated START and STOP conditions, and it answers to one fixed 7-bit device address. It never drives SCL. It pulls SDA low through a drive-low enable that the chip's open-drain pad turns into a wired-AND bus.

An internal register pointer picks the register for each data byte. The first byte after a write header loads the pointer. Each later byte of that write goes to the register the pointer selects, and the pointer then moves on. A read header makes the block send the selected register's byte, and the pointer moves on after every byte it sends. The block keeps sending bytes for as long as the controller acknowledges them. To read from a chosen register, the controller does a write that carries only the register address, then issues a repeated START and a read header. The pointer survives the repeated START.

Top module: `i2c_regfile_target`

## Requirements
- R1: The device address is 1101000, so header D0h selects a write and D1h selects a read. Any other header gets no ACK, and the block then ignores the bus until the next START or STOP. Bytes clocked during that time are neither acknowledged nor stored.
- R2: In a write, the first byte after the header is acknowledged and loads the register pointer. Only its low log2(NREGS) bits are used.
- R3: Each later byte of a write is acknowledged, stored at the pointer, and the pointer then advances by one. For example, writing 02h then 11h from register 04h leaves 02h in register 04h and 11h in register 05h.
- R4: A write that carries only a register address, followed by a repeated START and header D1h, returns the byte at that address. The pointer is not changed by the START.
- R5: In a read, the block sends the byte at the pointer, and the pointer advances by one after every byte sent, including the last one. A read header with no address byte before it starts at the current pointer.
- R6: After the controller leaves the ninth bit of a read byte high (NACK), the block releases SDA and stays silent until the next START or STOP.
- R7: The pointer wraps from NREGS-1 to 0, in writes and in reads.
- R8: A START or STOP that arrives while a byte is only partly clocked abandons that byte. The bit count restarts, nothing is written, and the pointer keeps its value.
- R9: SDA is only ever pulled low or released. The drive changes only while the synchronized SCL is low, and SCL is never held.
- R10: After reset every register holds 00h, the pointer is 0 and SDA is released.
- R11: Bytes travel MSB first. The block acknowledges by pulling SDA low for the whole ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the bus lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the I2C clock line |
| sda_i | input | 1 | Level of the I2C data line |
| sda_low_o | output | 1 | Drive-low enable for the open-drain SDA pad (1 pulls SDA low) |

## Verification
The assertions check four things on every cycle:
- the SDA drive holds still while the synchronized SCL stays high;
- the block is silent whenever it is ignoring the bus;
- a START or STOP resets the byte engine without touching the pointer;
- each stored byte moves the pointer on by exactly one, wrapping at the top.

Only the bench scenarios can show the rest, because it depends on whole transactions:
- which headers are acknowledged;
- that the data sent back matches what was written earlier, across a repeated START and across the wrap from the last register to register 0;
- that a byte cut short stores nothing;
- that a read ended by a NACK moves the pointer exactly once more.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HDR     = 3'd1,
    ST_HDR_ACK = 3'd2,
    ST_WR      = 3'd3,
    ST_WR_ACK  = 3'd4,
    ST_RD      = 3'd5,
    ST_RD_ACK  = 3'd6,
    ST_IGNORE  = 3'd7
  } tgt_state_t;

  localparam int unsigned BYTE_W = 8;

  // A header selects this target when its upper seven bits equal the address.
  function automatic logic hdr_selects(input logic [7:0] hdr, input logic [6:0] dev);
    return hdr[7:1] == dev;
  endfunction

  // Bit 0 of the header is the direction: 1 means the controller reads.
  function automatic logic hdr_is_read(input logic [7:0] hdr);
    return hdr[0];
  endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_q;
  logic              sda_q;

  // The idle bus is high, so the chains reset to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_q     <= scl_chain[STAGES-1];
      sda_q     <= sda_chain[STAGES-1];
    end
  end

  assign scl_lvl   = scl_chain[STAGES-1];
  assign sda_lvl   = sda_chain[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  // SDA moving while SCL stays high marks a bus condition.
  assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] regs [NREGS];

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[gi] <= '0;
      end else if (we && (waddr == PW'(gi))) begin
        regs[gi] <= wdata;
      end
    end
  end

  assign rdata = regs[raddr];

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h68,
  parameter int unsigned NREGS    = 16,
  localparam int unsigned PW      = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic [PW-1:0]     ptr,
  output logic              sda_low,
  output tgt_state_t        state,
  output logic [3:0]        bitcnt,
  output logic              byte_end
);

  localparam logic [3:0] FULL = 4'd8;

  logic [BYTE_W-1:0] shreg;
  logic              rw_q;
  logic              first_q;

  // Advance the pointer by one and wrap after the last register.
  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
    return (p == PW'(NREGS - 1)) ? '0 : PW'(p + 1'b1);
  endfunction

  // SCL falls after the eighth bit: the byte is complete.
  assign byte_end = scl_fall && (bitcnt == FULL);
  assign wr_en    = (state == ST_WR) && byte_end && !first_q;
  assign wr_data  = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr     <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      sda_low <= 1'b0;
    end else if (start_evt) begin
      state   <= ST_HDR;
      bitcnt  <= '0;
      sda_low <= 1'b0;
    end else if (stop_evt) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      sda_low <= 1'b0;
    end else begin
      unique case (state)
        ST_HDR, ST_WR: begin
          if (scl_rise && (bitcnt != FULL)) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end
          if (byte_end) begin
            if (state == ST_HDR) begin
              if (hdr_selects(shreg, DEV_ADDR)) begin
                rw_q    <= hdr_is_read(shreg);
                state   <= ST_HDR_ACK;
                sda_low <= 1'b1;
              end else begin
                state <= ST_IGNORE;
              end
            end else begin
              if (first_q) begin
                ptr     <= shreg[PW-1:0];
                first_q <= 1'b0;
              end else begin
                ptr <= ptr_step(ptr);
              end
              state   <= ST_WR_ACK;
              sda_low <= 1'b1;
            end
          end
        end
        ST_HDR_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw_q) begin
              state   <= ST_RD;
              shreg   <= rd_data;
              sda_low <= ~rd_data[BYTE_W-1];
            end else begin
              state   <= ST_WR;
              first_q <= 1'b1;
              sda_low <= 1'b0;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            state   <= ST_WR;
            bitcnt  <= '0;
            sda_low <= 1'b0;
          end
        end
        ST_RD: begin
          if (scl_rise && (bitcnt != FULL)) begin
            bitcnt <= bitcnt + 4'd1;
          end
          if (scl_fall) begin
            if (bitcnt == FULL) begin
              state   <= ST_RD_ACK;
              sda_low <= 1'b0;
              ptr     <= ptr_step(ptr);
            end else begin
              shreg   <= {shreg[BYTE_W-2:0], 1'b0};
              sda_low <= ~shreg[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise && sda_lvl) begin
            state <= ST_IGNORE;
          end else if (scl_fall) begin
            state   <= ST_RD;
            bitcnt  <= '0;
            shreg   <= rd_data;
            sda_low <= ~rd_data[BYTE_W-1];
          end
        end
        default: begin
          sda_low <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h68,
  parameter int unsigned NREGS       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_low_o
);

  localparam int unsigned PTR_W = $clog2(NREGS);

  logic              scl_lvl;
  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_evt;
  logic              stop_evt;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] rd_data;
  logic [PTR_W-1:0]  ptr;
  logic              sda_low;
  tgt_state_t        state;
  logic [3:0]        bitcnt;
  logic              byte_end;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .NREGS(NREGS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ptr       (ptr),
    .sda_low   (sda_low),
    .state     (state),
    .bitcnt    (bitcnt),
    .byte_end  (byte_end)
  );

  i2c_regbank #(.NREGS(NREGS), .DW(BYTE_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (ptr),
    .wdata (wr_data),
    .raddr (ptr),
    .rdata (rd_data)
  );

  assign sda_low_o = sda_low;

endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_lvl,
  input logic          start_evt,
  input logic          stop_evt,
  input logic          sda_low,
  input tgt_state_t    state,
  input logic [3:0]    bitcnt,
  input logic [PW-1:0] ptr,
  input logic          wr_en
);

  // R9: the drive only moves while synchronized SCL is low
  a_r9_drive_still_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl)) |-> $stable(sda_low));

  // R1 and R6: a target that ignores the bus never pulls SDA
  a_r6_silent_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_low);

  // R8: a START restarts the header with a clear bit count
  a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> ((state == ST_HDR) && (bitcnt == 4'd0)));

  // R8: a STOP returns the target to idle with SDA released
  a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> ((state == ST_IDLE) && !sda_low));

  // R8: bus conditions never move the pointer
  a_r8_ptr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> $stable(ptr));

  // R3 and R7: each stored byte steps the pointer by one, modulo the bank size
  a_r3_write_steps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == PW'($past(ptr) + 1'b1)));

  // R11: never more than eight bits counted in one byte
  a_r11_bitcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);

endmodule

bind i2c_regfile_target i2c_tgt_checker #(.PW(PTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_lvl   (scl_lvl),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .sda_low   (sda_low),
  .state     (state),
  .bitcnt    (bitcnt),
  .ptr       (ptr),
  .wr_en     (wr_en)
);

// File: tb/sim_i2c_regfile_target.sv
`timescale 1ns/1ps
module sim_i2c_regfile_target;

  localparam int Q     = 8;   // quarter of an SCL period, in clk cycles
  localparam int NR    = 16;
  localparam logic [7:0] HDR_W = 8'hD0;
  localparam logic [7:0] HDR_R = 8'hD1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic ctl_low = 1'b0;
  logic sda_low_o;
  logic sda_bus;

  always #4 clk = ~clk;   // 125 MHz

  assign sda_bus = !(ctl_low || sda_low_o);

  i2c_regfile_target u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_drv),
    .sda_i     (sda_bus),
    .sda_low_o (sda_low_o)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  bit    exp_on = 1'b0;
  bit    exp_low = 1'b0;
  string cur_req = "R9";

  logic [7:0] mregs [NR];
  int         mptr = 0;
  logic [7:0] txq [$];

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference comparison of the SDA drive, every clock while SCL is high
  always @(negedge clk) begin
    if (exp_on && rst_n) begin
      n_chk++;
      if (sda_low_o !== exp_low) begin
        n_fail++;
        if (n_fail < 20)
          $display("FAIL %s/R9 sda drive actual=%0b expected=%0b at %0t",
                   cur_req, sda_low_o, exp_low, $time);
      end
    end
  end

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clock_bit(input bit drive_low, input bit want_low, output bit seen);
    ctl_low = drive_low;
    waitq();
    scl_drv = 1'b1;
    waitq();
    exp_low = want_low;
    exp_on  = 1'b1;
    seen    = sda_bus;
    waitq();
    exp_on  = 1'b0;
    scl_drv = 1'b0;
  endtask

  task automatic bus_start();
    ctl_low = 1'b0;
    waitq();
    scl_drv = 1'b1;
    waitq();
    ctl_low = 1'b1;
    waitq();
    scl_drv = 1'b0;
    waitq();
  endtask

  task automatic bus_stop();
    ctl_low = 1'b1;
    waitq();
    scl_drv = 1'b1;
    waitq();
    ctl_low = 1'b0;
    waitq();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit want_ack, input string req);
    bit s;
    for (int i = 7; i >= 0; i--) clock_bit(!b[i], 1'b0, s);
    clock_bit(1'b0, want_ack, s);
    check(s == !want_ack, {req, "/R11 ack bit"}, {7'd0, s}, {7'd0, !want_ack});
  endtask

  task automatic recv_byte(input bit ack, input logic [7:0] exp, input string req);
    bit s;
    logic [7:0] got;
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b0, !exp[i], s);
      got[i] = s;
    end
    clock_bit(ack, 1'b0, s);
    check(got == exp, {req, "/R11 read byte"}, got, exp);
  endtask

  task automatic wr_txn(input logic [7:0] addr, input string req);
    cur_req = req;
    bus_start();
    send_byte(HDR_W, 1'b1, "R1");
    send_byte(addr, 1'b1, "R2");
    mptr = addr % NR;
    foreach (txq[k]) begin
      send_byte(txq[k], 1'b1, "R3");
      mregs[mptr] = txq[k];
      mptr = (mptr + 1) % NR;
    end
    bus_stop();
    txq.delete();
  endtask

  task automatic rd_txn(input bit set_addr, input logic [7:0] addr, input int n, input string req);
    cur_req = req;
    bus_start();
    if (set_addr) begin
      send_byte(HDR_W, 1'b1, "R1");
      send_byte(addr, 1'b1, "R4");
      mptr = addr % NR;
      bus_start();
    end
    send_byte(HDR_R, 1'b1, "R1");
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, mregs[mptr], req);
      mptr = (mptr + 1) % NR;
    end
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < NR; i++) mregs[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_low_o == 1'b0, "R10 sda released after reset", {7'd0, sda_low_o}, 8'h00);

    // R10: registers clear and pointer at 0; R5 current-pointer read
    rd_txn(1'b0, 8'h00, 2, "R10");

    // R2/R3: example write of 02h, 11h from register 04h
    txq.push_back(8'h02); txq.push_back(8'h11);
    wr_txn(8'h04, "R3");
    // R4: random read across a repeated START
    rd_txn(1'b1, 8'h04, 2, "R4");
    // R5: pointer advanced past the last byte read; a fresh read continues at 06h
    rd_txn(1'b0, 8'h00, 1, "R5");

    // R1: a foreign header gets no ACK and later bytes are ignored
    begin
      bit s;
      cur_req = "R1";
      bus_start();
      send_byte(8'hA0, 1'b0, "R1");
      send_byte(8'h05, 1'b0, "R1");
      send_byte(8'h77, 1'b0, "R1");
      bus_stop();
      bus_start();
      send_byte(8'hD2, 1'b0, "R1");
      for (int i = 0; i < 9; i++) clock_bit(1'b1, 1'b0, s);
      bus_stop();
    end
    rd_txn(1'b1, 8'h05, 1, "R1");

    // R7: wrap in a write and in a read
    txq.push_back(8'hAA); txq.push_back(8'hBB); txq.push_back(8'h3C);
    wr_txn(8'h0F, "R7");
    rd_txn(1'b1, 8'h0F, 3, "R7");
    // R2: address bits above the pointer width are dropped (13h selects 03h)
    txq.push_back(8'h96);
    wr_txn(8'h13, "R2");
    rd_txn(1'b1, 8'h03, 1, "R2");

    // R6: after a NACK the bus is clocked again and the target stays silent
    begin
      bit s;
      cur_req = "R6";
      bus_start();
      send_byte(HDR_W, 1'b1, "R6");
      send_byte(8'h04, 1'b1, "R6");
      bus_start();
      send_byte(HDR_R, 1'b1, "R6");
      recv_byte(1'b0, mregs[4], "R6");
      mptr = 5;
      for (int i = 0; i < 9; i++) clock_bit(1'b0, 1'b0, s);
      bus_stop();
    end
    rd_txn(1'b0, 8'h00, 1, "R6");   // reads 05h: one advance only

    // R8: START in the middle of a data byte, pointer kept, nothing stored
    txq.push_back(8'hC3);
    wr_txn(8'h09, "R8");
    begin
      bit s;
      cur_req = "R8";
      bus_start();
      send_byte(HDR_W, 1'b1, "R8");
      send_byte(8'h09, 1'b1, "R8");
      mptr = 9;
      for (int i = 0; i < 4; i++) clock_bit(1'b0, 1'b0, s);
      bus_start();
      send_byte(HDR_R, 1'b1, "R8");
      recv_byte(1'b0, mregs[mptr], "R8");
      mptr = (mptr + 1) % NR;
      bus_stop();
      // R8: STOP in the middle of a header, then a current-pointer read
      bus_start();
      for (int i = 0; i < 3; i++) clock_bit(1'b1, 1'b0, s);
      bus_stop();
    end
    rd_txn(1'b0, 8'h00, 1, "R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule